// File: doc/BRIEF.md
# Interrupt Enable, Mask and Routing Controller

This block gathers up to `NSRC` level-sensitive interrupt sources and delivers them to `NCPU` processors. Software reaches it through a single-cycle register port with two address spaces. The shared space holds a global enable bit and a control word for each source. The control word selects the CPUs that source is steered to and holds a set of fast-interrupt enable bits. The banked space is private to the processor named by `cpu_id` on each access. It holds that processor's mask and an acknowledge register.

Enables and masks are never rewritten as whole bitmaps. Software writes a source number to a "set" or a "clear" offset, so several agents can change them without a read-modify-write race. Each CPU's interrupt line is raised while a source qualifies for it. The acknowledge register names the lowest-numbered qualifying source. One designated source, the private timer, ignores the global enable and is gated only by each CPU's own mask.

Top module: `icr_ctrl`

## Requirements
- R1: After reset all global enables are 0, every source is masked for every CPU, and all control words read 0. So `irq_o` is 0 whatever `src_level` is, and the acknowledge register reads 1023.
- R2: A read of shared offset 0x000 returns `NSRC` in bits [11:2] and 0 in all other bits.
- R3: A write to shared offset 0x030 sets the global enable of the source whose number is in `wdata[9:0]`. A write to 0x034 clears it.
- R4: The control word of source n is at shared offset 0x100 + 4n. Bit c is the routing bit for CPU c and bit 8+c is the fast-interrupt enable for CPU c. Both fields read back as written, all other bits read 0, and the fast-interrupt bits have no effect on `irq_o`.
- R5: A write of a source number in `wdata[9:0]` to banked offset 0x048 masks that source for the CPU given by `cpu_id`. A write to 0x04C unmasks it. No other CPU's mask changes.
- R6: `irq_o[c]` is 1 exactly when some source is high on `src_level`, globally enabled, routed to CPU c and unmasked for CPU c.
- R7: A read of banked offset 0x044 returns in bits [9:0] the lowest-numbered source that qualifies for `cpu_id` under R6, or 1023 when none does. Reading it changes no state.
- R8: Source `TIMER_SRC` qualifies without its global enable. It still needs routing, a high level and an unmasked bit for the CPU.
- R9: An enable or mask write whose source number in `wdata[9:0]` is `NSRC` or more changes nothing, even when its low bits name a real source.
- R10: Read data appears on `rdata` on the clock edge after `rd_en`. Offsets that map to nothing read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| pcpu_sel | input | 1 | 1 selects the banked per-CPU space, 0 the shared space |
| addr | input | 12 | Byte offset within the selected space |
| wdata | input | 32 | Write data |
| cpu_id | input | CPU_W | Processor performing the access |
| src_level | input | NSRC | Level of each interrupt source |
| rdata | output | 32 | Registered read data |
| irq_o | output | NCPU | Interrupt request per CPU |

## Verification
The bench builds the block with its defaults: 32 sources, 4 CPUs and the timer at source 5. With 32 sources, the source numbers 33 and 37 alias sources 1 and 5 in their low five bits. That makes the out-of-range rejection visible: a design that truncated the index would re-enable or unmask a real source. With 4 CPUs, the routing and fast-interrupt fields fill whole nibbles, so their readback and the independence of different CPUs' masks are checked on distinct processors.

// File: rtl/icr_pkg.sv
`timescale 1ns/1ps
package icr_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 10;

    localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_ACK      = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET  = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR  = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_SRC_BASE = 12'h100;

    localparam logic [IDX_W-1:0] NO_IRQ = 10'd1023;
endpackage

// File: rtl/icr_src_bank.sv
`timescale 1ns/1ps
module icr_src_bank
    import icr_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCPU  = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           pcpu_sel,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [CPU_W-1:0]               cpu_id,
    output logic [NSRC-1:0]                gen_en_q,
    output logic [NSRC-1:0][NCPU-1:0]      route_q,
    output logic [NSRC-1:0][NCPU-1:0]      fiq_q,
    output logic [NCPU-1:0][NSRC-1:0]      mask_q
);
    localparam int SIDX_W = $clog2(NSRC);

    logic              idx_ok;
    logic [SIDX_W-1:0] idx;
    logic [ADDR_W-1:0] off;
    logic              slot_hit;
    logic [SIDX_W-1:0] slot;

    assign idx_ok   = wdata[IDX_W-1:0] < IDX_W'(NSRC);
    assign idx      = wdata[SIDX_W-1:0];
    assign off      = addr - OFS_SRC_BASE;
    assign slot_hit = (addr >= OFS_SRC_BASE) && (off < ADDR_W'(4*NSRC)) && (addr[1:0] == 2'b00);
    assign slot     = off[2 +: SIDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en_q <= '0;
            route_q  <= '0;
            fiq_q    <= '0;
            mask_q   <= '1;
        end else if (wr_en) begin
            if (!pcpu_sel) begin
                if (addr == OFS_EN_SET && idx_ok) gen_en_q[idx] <= 1'b1;
                if (addr == OFS_EN_CLR && idx_ok) gen_en_q[idx] <= 1'b0;
                if (slot_hit) begin
                    route_q[slot] <= wdata[NCPU-1:0];
                    fiq_q[slot]   <= wdata[8 +: NCPU];
                end
            end else begin
                if (addr == OFS_MSK_SET && idx_ok) mask_q[cpu_id][idx] <= 1'b1;
                if (addr == OFS_MSK_CLR && idx_ok) mask_q[cpu_id][idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/icr_lowest.sv
`timescale 1ns/1ps
module icr_lowest
    import icr_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0]  req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = NO_IRQ;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (req[s]) idx = IDX_W'(s);
        end
        hit = |req;
    end
endmodule

// File: rtl/icr_ctrl.sv
`timescale 1ns/1ps
module icr_ctrl
    import icr_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int NCPU      = 4,
    parameter int TIMER_SRC = 5,
    parameter int CPU_W     = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              pcpu_sel,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    input  logic [CPU_W-1:0]  cpu_id,
    input  logic [NSRC-1:0]   src_level,
    output logic [31:0]       rdata,
    output logic [NCPU-1:0]   irq_o
);
    localparam int SIDX_W = $clog2(NSRC);

    logic [NSRC-1:0]               gen_en_q;
    logic [NSRC-1:0][NCPU-1:0]     route_q;
    logic [NSRC-1:0][NCPU-1:0]     fiq_q;
    logic [NCPU-1:0][NSRC-1:0]     mask_q;
    logic [NCPU-1:0][NSRC-1:0]     elig;
    logic [NCPU-1:0][IDX_W-1:0]    ack_idx;

    icr_src_bank #(.NSRC(NSRC), .NCPU(NCPU), .CPU_W(CPU_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .pcpu_sel(pcpu_sel),
        .addr(addr), .wdata(wdata), .cpu_id(cpu_id),
        .gen_en_q(gen_en_q), .route_q(route_q), .fiq_q(fiq_q), .mask_q(mask_q)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            if (s == TIMER_SRC) begin : g_timer
                assign elig[c][s] = src_level[s] & route_q[s][c] & ~mask_q[c][s];
            end else begin : g_shared
                assign elig[c][s] = src_level[s] & route_q[s][c] & ~mask_q[c][s] & gen_en_q[s];
            end
        end
        icr_lowest #(.NSRC(NSRC)) u_pick (
            .req(elig[c]), .hit(irq_o[c]), .idx(ack_idx[c])
        );
    end

    logic [ADDR_W-1:0] off;
    logic              slot_hit;
    logic [SIDX_W-1:0] slot;
    logic [DATA_W-1:0] rd_word;

    assign off      = addr - OFS_SRC_BASE;
    assign slot_hit = (addr >= OFS_SRC_BASE) && (off < ADDR_W'(4*NSRC)) && (addr[1:0] == 2'b00);
    assign slot     = off[2 +: SIDX_W];

    always_comb begin
        rd_word = '0;
        if (pcpu_sel) begin
            if (addr == OFS_ACK) rd_word[IDX_W-1:0] = ack_idx[cpu_id];
        end else if (addr == OFS_CTRL) begin
            rd_word[11:2] = 10'(NSRC);
        end else if (slot_hit) begin
            rd_word[NCPU-1:0]  = route_q[slot];
            rd_word[8 +: NCPU] = fiq_q[slot];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end
endmodule

// File: rtl/icr_ctrl_chk.sv
`timescale 1ns/1ps
module icr_ctrl_chk
    import icr_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCPU  = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              pcpu_sel,
    input logic [11:0]       addr,
    input logic [31:0]       wdata,
    input logic [CPU_W-1:0]  cpu_id,
    input logic [NSRC-1:0]   src_level,
    input logic [31:0]       rdata,
    input logic [NCPU-1:0]   irq_o,
    input logic [NSRC-1:0]   gen_en_q
);
    localparam int SIDX_W = $clog2(NSRC);

    // R2
    ctrl_count_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !pcpu_sel && addr == OFS_CTRL) |=> (rdata[11:2] == 10'(NSRC)));

    // R6
    irq_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src_level == '0) |-> (irq_o == '0));

    // R7
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && pcpu_sel && addr == OFS_ACK && !irq_o[cpu_id]) |=> (rdata == 32'd1023));

    // R7
    ack_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && pcpu_sel && addr == OFS_ACK && irq_o[cpu_id]) |=> (rdata < 32'(NSRC)));

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pcpu_sel && addr == OFS_EN_SET && wdata[IDX_W-1:0] < IDX_W'(NSRC))
        |=> gen_en_q[$past(wdata[SIDX_W-1:0])]);

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pcpu_sel && addr == OFS_EN_CLR && wdata[IDX_W-1:0] < IDX_W'(NSRC))
        |=> !gen_en_q[$past(wdata[SIDX_W-1:0])]);
endmodule

bind icr_ctrl icr_ctrl_chk #(.NSRC(NSRC), .NCPU(NCPU), .CPU_W(CPU_W)) u_icr_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .pcpu_sel(pcpu_sel),
    .addr(addr), .wdata(wdata), .cpu_id(cpu_id), .src_level(src_level),
    .rdata(rdata), .irq_o(irq_o), .gen_en_q(gen_en_q)
);

// File: tb/icr_ctrl_bench.sv
`timescale 1ns/1ps
module icr_ctrl_bench;
    localparam int NSRC = 32;
    localparam int NCPU = 4;

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 read-compare, 2 irq-compare
        logic        pc;
        logic [1:0]  cpu;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] src;
        logic [31:0] exp;
        logic [7:0]  req;
    } row_t;

    localparam int NROW = 28;
    localparam row_t TBL [NROW] = '{
        '{2'd1,1'b0,2'd0,12'h000,32'h0,  32'h0,  32'h80, 8'd2},  // R2 source count
        '{2'd1,1'b1,2'd0,12'h044,32'h0,  32'h0,  32'h3FF,8'd1},  // R1 idle ack
        '{2'd0,1'b0,2'd0,12'h104,32'h103,32'h0,  32'h0,  8'd4},
        '{2'd1,1'b0,2'd0,12'h104,32'h0,  32'h0,  32'h103,8'd4},  // R4 readback
        '{2'd0,1'b0,2'd0,12'h030,32'h1,  32'h0,  32'h0,  8'd3},
        '{2'd0,1'b1,2'd0,12'h04C,32'h1,  32'h0,  32'h0,  8'd5},
        '{2'd2,1'b0,2'd0,12'h000,32'h0,  32'h2,  32'h1,  8'd6},  // R6 cpu0 only
        '{2'd1,1'b1,2'd0,12'h044,32'h0,  32'h2,  32'h1,  8'd7},  // R7
        '{2'd1,1'b1,2'd1,12'h044,32'h0,  32'h2,  32'h3FF,8'd5},  // R5 cpu1 still masked
        '{2'd0,1'b0,2'd0,12'h108,32'h1,  32'h0,  32'h0,  8'd4},
        '{2'd0,1'b0,2'd0,12'h030,32'h2,  32'h0,  32'h0,  8'd3},
        '{2'd0,1'b1,2'd0,12'h04C,32'h2,  32'h0,  32'h0,  8'd5},
        '{2'd1,1'b1,2'd0,12'h044,32'h0,  32'h6,  32'h1,  8'd7},  // R7 lowest wins
        '{2'd0,1'b0,2'd0,12'h034,32'h1,  32'h0,  32'h0,  8'd3},
        '{2'd1,1'b1,2'd0,12'h044,32'h0,  32'h6,  32'h2,  8'd3},  // R3 clear enable
        '{2'd0,1'b1,2'd0,12'h048,32'h2,  32'h0,  32'h0,  8'd5},
        '{2'd2,1'b0,2'd0,12'h000,32'h0,  32'h6,  32'h0,  8'd5},  // R5 mask
        '{2'd0,1'b0,2'd0,12'h114,32'h4,  32'h0,  32'h0,  8'd8},
        '{2'd0,1'b1,2'd2,12'h04C,32'h5,  32'h0,  32'h0,  8'd8},
        '{2'd2,1'b0,2'd0,12'h000,32'h0,  32'h20, 32'h4,  8'd8},  // R8 no enable needed
        '{2'd1,1'b1,2'd2,12'h044,32'h0,  32'h20, 32'h5,  8'd8},  // R8
        '{2'd0,1'b1,2'd2,12'h048,32'h5,  32'h0,  32'h0,  8'd8},
        '{2'd2,1'b0,2'd0,12'h000,32'h0,  32'h20, 32'h0,  8'd8},  // R8 mask gates timer
        '{2'd0,1'b1,2'd2,12'h04C,32'h25, 32'h0,  32'h0,  8'd9},
        '{2'd2,1'b0,2'd0,12'h000,32'h0,  32'h20, 32'h0,  8'd9},  // R9 index 37 ignored
        '{2'd0,1'b0,2'd0,12'h030,32'h21, 32'h0,  32'h0,  8'd9},
        '{2'd1,1'b1,2'd0,12'h044,32'h0,  32'h2,  32'h3FF,8'd9},  // R9 index 33 ignored
        '{2'd1,1'b0,2'd0,12'h0FC,32'h0,  32'h0,  32'h0,  8'd10}  // R10 unmapped
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0, rd_en = 1'b0, pcpu_sel = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [1:0]      cpu_id = '0;
    logic [NSRC-1:0] src_level = '0;
    logic [31:0]     rdata;
    logic [NCPU-1:0] irq_o;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    icr_ctrl #(.NSRC(NSRC), .NCPU(NCPU), .TIMER_SRC(5)) u_icr_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .pcpu_sel(pcpu_sel),
        .addr(addr), .wdata(wdata), .cpu_id(cpu_id), .src_level(src_level),
        .rdata(rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic pc, input logic [1:0] cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; pcpu_sel = pc; cpu_id = cpu; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic pc, input logic [1:0] cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; pcpu_sel = pc; cpu_id = cpu; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state: every source high, nothing delivered
        src_level = '1;
        #1 check("R1 irq after reset", 32'(irq_o), 32'h0);
        rd(1'b0, 2'd0, 12'h17C, v);
        check("R1 control word after reset", v, 32'h0);
        src_level = '0;

        for (int i = 0; i < NROW; i++) begin
            row_t r;
            r = TBL[i];
            @(negedge clk);
            src_level = r.src;
            case (r.kind)
                2'd0: wr(r.pc, r.cpu, r.a, r.d);
                2'd1: begin
                    rd(r.pc, r.cpu, r.a, v);
                    check($sformatf("R%0d row %0d read", r.req, i), v, r.exp);
                end
                default: begin
                    #1 check($sformatf("R%0d row %0d irq", r.req, i), 32'(irq_o), r.exp);
                end
            endcase
        end

        // R7 acknowledge read has no side effect: two reads agree
        wr(1'b1, 2'd2, 12'h04C, 32'h5);
        src_level = 32'h20;
        rd(1'b1, 2'd2, 12'h044, v);
        rd(1'b1, 2'd2, 12'h044, v2);
        check("R7 first ack", v, 32'h5);
        check("R7 repeat ack", v2, 32'h5);

        // R1 reset mid-run restores masked, disabled, unrouted state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        src_level = '1;
        #1 check("R1 irq after second reset", 32'(irq_o), 32'h0);
        rd(1'b0, 2'd0, 12'h104, v);
        check("R1 word cleared by reset", v, 32'h0);
        rd(1'b1, 2'd1, 12'h044, v);
        check("R1 ack after reset", v, 32'h3FF);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule